// File: doc/BRIEF.md
# Strobed Word Capture with Pulse Analysis

This block records a parallel word of drive lines each time an external sampling strobe rises. The strobe runs independently of the system clock, so the block synchronises it and turns each rising edge into a one-cycle sample event. Each sample is written to an internal buffer at the next free slot, and a readback port can read the buffer afterwards.

While samples arrive, the block measures the stream as it goes. For every bit it counts each run of consecutive one-samples, and it keeps the longest run seen on that bit. It also counts how many bits are high in each sample and keeps the largest such count, which is the peak overlap. A start pulse clears the buffer and every result, and then arms the capture. The capture ends on its own after a programmed number of samples, or earlier on a stop pulse. Any run still open at the end is closed and included in the results.

Top module: `strobe_capture_analyzer`

## Requirements
- R1: After reset, `capturing`, `done`, `samplesTaken`, `peakOverlap`, `runLongest` and `rdData` are all zero.
- R2: A `startCapture` pulse clears the sample count, the peak overlap, every per-bit result and every buffer entry, so that every address then reads back zero.
- R3: Each rising edge of `sampleStrobe` seen while capturing stores `dataIn` at the next buffer address, starting from address 0. `rdData` shows the entry at `rdAddr` one clock after the address is applied.
- R4: Samples past the buffer depth are not stored, and earlier entries are never overwritten. These samples are still counted and analysed.
- R5: After `sampleLimit` samples (latched at start), `capturing` falls and `done` rises and stays high. Later strobes change neither the count nor the buffer.
- R6: A `stopCapture` pulse during capture ends it early. The results then cover exactly the samples taken so far.
- R7: `runLongest` gives the longest run, counted in samples, of consecutive ones on the bit chosen by `runBitSel`.
- R8: A run of ones that is still open when capture ends is included in `runLongest`.
- R9: A run count saturates at 2^RUN_W-1 and does not wrap.
- R10: `peakOverlap` is the largest number of ones found in any single captured sample.
- R11: Strobes that arrive before the first start, or after capture has ended, are ignored.
- R12: When `sampleLimit` is 0, the capture ends at once with zero samples taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleStrobe | input | 1 | External sampling strobe, asynchronous |
| dataIn | input | DATA_W | Drive-line word, held stable around each strobe edge |
| startCapture | input | 1 | One-cycle pulse: clear everything and arm capture |
| stopCapture | input | 1 | One-cycle pulse: end capture early |
| sampleLimit | input | CNT_W | Number of samples to take |
| rdAddr | input | ADDR_W | Buffer readback address |
| rdData | output | DATA_W | Registered buffer readback data |
| capturing | output | 1 | Capture in progress |
| done | output | 1 | Capture has finished |
| samplesTaken | output | CNT_W | Samples taken since the last start |
| peakOverlap | output | OVL_W | Largest population count seen |
| runBitSel | input | SEL_W | Bit chosen for run readback |
| runLongest | output | RUN_W | Longest run of ones on the chosen bit |

## Verification
The hardest case to reach from the ports is a run count that saturates while the buffer has already filled and samples keep coming. Reaching it needs more one-samples on a single bit than both the counter range and the buffer depth. The bench therefore builds the block with a narrow run width and a shallow buffer, and drives one long capture with bit 0 held high and a varying upper byte. That single capture shows saturation, the non-wrapping buffer and the peak overlap together.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Control-to-datapath strobes, at most one per cycle
  typedef struct packed {
    logic clearAll;
    logic takeSample;
    logic closeRuns;
  } capCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } capState_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeIn,
  output logic strobeEdge
);

  logic [STAGES-1:0] syncChain;
  logic              syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      syncPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[STAGES-2:0], strobeIn};
      syncPrev  <= syncChain[STAGES-1];
    end
  end

  assign strobeEdge = syncChain[STAGES-1] & ~syncPrev;

  // R3: one event per strobe edge
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeEdge |=> !strobeEdge);

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobeEdge,
  input  logic             startCapture,
  input  logic             stopCapture,
  input  logic [CNT_W-1:0] sampleLimit,
  input  logic [CNT_W-1:0] sampleCount,
  output capCtrl_t         ctrl,
  output logic             capturing,
  output logic             done
);

  capState_t        state, nextState;
  logic [CNT_W-1:0] limitReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      limitReg <= '0;
    end else begin
      state <= nextState;
      if (startCapture) limitReg <= sampleLimit;
    end
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    if (startCapture) begin
      ctrl.clearAll = 1'b1;
      nextState     = ST_RUN;
    end else if (state == ST_RUN) begin
      if (sampleCount == limitReg || stopCapture) begin
        ctrl.closeRuns = 1'b1;
        nextState      = ST_DONE;
      end else if (strobeEdge) begin
        ctrl.takeSample = 1'b1;
      end
    end
  end

  assign capturing = (state == ST_RUN);
  assign done      = (state == ST_DONE);

  // R5
  count_within_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    capturing |-> sampleCount <= limitReg);

  // R5
  finish_on_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capturing && sampleCount == limitReg && !startCapture) |=> done);

  // R11
  idle_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!capturing && !startCapture) |=> $stable(sampleCount));

  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(capturing && done));

endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import cap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 16,
  parameter int RUN_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int OVL_W  = $clog2(DATA_W + 1),
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  capCtrl_t          ctrl,
  input  logic [DATA_W-1:0] sampleWord,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  sampleCount,
  output logic [OVL_W-1:0]  peakOverlap,
  input  logic [SEL_W-1:0]  runBitSel,
  output logic [RUN_W-1:0]  runLongest
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W:0]   DEPTH_C = (CNT_W + 1)'(DEPTH);

  // Sample buffer with per-entry valid flags for a single-cycle clear
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic              inBuffer;
  logic [ADDR_W-1:0] wrIdx;

  assign inBuffer = ({1'b0, sampleCount} < DEPTH_C);
  assign wrIdx    = sampleCount[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  valid <= '0;
    else if (ctrl.clearAll)                     valid <= '0;
    else if (ctrl.takeSample && inBuffer)       valid[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctrl.takeSample && inBuffer) mem[wrIdx] <= sampleWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (valid[rdAddr]) rdData <= mem[rdAddr];
    else                    rdData <= '0;
  end

  // Sample counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sampleCount <= '0;
    else if (ctrl.clearAll)   sampleCount <= '0;
    else if (ctrl.takeSample) sampleCount <= sampleCount + 1'b1;
  end

  // Population count and peak overlap
  logic [OVL_W-1:0] onesNow;
  always_comb begin
    onesNow = '0;
    for (int i = 0; i < DATA_W; i++) onesNow = onesNow + OVL_W'(sampleWord[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             peakOverlap <= '0;
    else if (ctrl.clearAll) peakOverlap <= '0;
    else if (ctrl.takeSample && onesNow > peakOverlap) peakOverlap <= onesNow;
  end

  // Per-bit run trackers
  logic [RUN_W-1:0] curRun  [DATA_W];
  logic [RUN_W-1:0] bestRun [DATA_W];

  for (genvar g = 0; g < DATA_W; g++) begin : g_run
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curRun[g]  <= '0;
        bestRun[g] <= '0;
      end else if (ctrl.clearAll) begin
        curRun[g]  <= '0;
        bestRun[g] <= '0;
      end else if (ctrl.takeSample && sampleWord[g]) begin
        if (curRun[g] != RUN_MAX) curRun[g] <= curRun[g] + 1'b1;
      end else if (ctrl.takeSample || ctrl.closeRuns) begin
        if (curRun[g] > bestRun[g]) bestRun[g] <= curRun[g];
        curRun[g] <= '0;
      end
    end
  end

  assign runLongest = bestRun[runBitSel];

  // R10
  peak_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.clearAll |=> peakOverlap >= $past(peakOverlap));

  // R2
  clear_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAll |=> (sampleCount == '0 && peakOverlap == '0 && valid == '0));

  // R4
  no_store_beyond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.takeSample && !inBuffer) |=> $stable(valid));

  // R9
  run_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.takeSample && sampleWord[0] && curRun[0] == RUN_MAX) |=> curRun[0] == RUN_MAX);

endmodule

// File: rtl/strobe_capture_analyzer.sv
module strobe_capture_analyzer
  import cap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 16,
  parameter int RUN_W  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int OVL_W  = $clog2(DATA_W + 1),
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStrobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              startCapture,
  input  logic              stopCapture,
  input  logic [CNT_W-1:0]  sampleLimit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              capturing,
  output logic              done,
  output logic [CNT_W-1:0]  samplesTaken,
  output logic [OVL_W-1:0]  peakOverlap,
  input  logic [SEL_W-1:0]  runBitSel,
  output logic [RUN_W-1:0]  runLongest
);

  logic     strobeEdge;
  capCtrl_t ctrl;

  strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .strobeIn(sampleStrobe), .strobeEdge(strobeEdge)
  );

  capture_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .strobeEdge(strobeEdge),
    .startCapture(startCapture), .stopCapture(stopCapture),
    .sampleLimit(sampleLimit), .sampleCount(samplesTaken),
    .ctrl(ctrl), .capturing(capturing), .done(done)
  );

  capture_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .RUN_W(RUN_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleWord(dataIn),
    .rdAddr(rdAddr), .rdData(rdData), .sampleCount(samplesTaken),
    .peakOverlap(peakOverlap), .runBitSel(runBitSel), .runLongest(runLongest)
  );

endmodule

// File: tb/test_strobe_capture_analyzer.sv
module test_strobe_capture_analyzer;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = 8;
  localparam int RUN_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleStrobe = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic              startCapture = 1'b0;
  logic              stopCapture = 1'b0;
  logic [CNT_W-1:0]  sampleLimit = '0;
  logic [3:0]        rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              capturing, done;
  logic [CNT_W-1:0]  samplesTaken;
  logic [5:0]        peakOverlap;
  logic [4:0]        runBitSel = '0;
  logic [RUN_W-1:0]  runLongest;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  strobe_capture_analyzer #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .RUN_W(RUN_W)
  ) i_strobe_capture_analyzer (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .dataIn(dataIn),
    .startCapture(startCapture), .stopCapture(stopCapture),
    .sampleLimit(sampleLimit), .rdAddr(rdAddr), .rdData(rdData),
    .capturing(capturing), .done(done), .samplesTaken(samplesTaken),
    .peakOverlap(peakOverlap), .runBitSel(runBitSel), .runLongest(runLongest)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startRun(input int limit);
    @(negedge clk);
    sampleLimit  = CNT_W'(limit);
    startCapture = 1'b1;
    @(negedge clk);
    startCapture = 1'b0;
  endtask

  task automatic strobeWord(input logic [31:0] w);
    @(negedge clk);
    dataIn = w;
    repeat (2) @(negedge clk);
    sampleStrobe = 1'b1;
    repeat (5) @(negedge clk);
    sampleStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
  endtask

  task automatic readWord(input int addr, output logic [31:0] w);
    @(negedge clk);
    rdAddr = 4'(addr);
    @(negedge clk);
    w = rdData;
  endtask

  task automatic longestOf(input int bitIdx, output logic [31:0] v);
    @(negedge clk);
    runBitSel = 5'(bitIdx);
    #1 v = 32'(runLongest);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 capturing", 32'(capturing), 0);
    check("R1 done", 32'(done), 0);
    check("R1 samplesTaken", 32'(samplesTaken), 0);
    check("R1 peakOverlap", 32'(peakOverlap), 0);
    check("R1 runLongest", 32'(runLongest), 0);
    check("R1 rdData", rdData, 0);
    strobeWord(32'hFFFF_FFFF); // R11: before any start
    check("R11 idle strobe count", 32'(samplesTaken), 0);
    readWord(0, v);
    check("R11 idle strobe buffer", v, 0);
  endtask

  task automatic testBasic();
    logic [31:0] v;
    logic [31:0] words [5] = '{32'h1, 32'h3, 32'h7, 32'h6, 32'h0};
    startRun(5);
    check("R5 capturing after start", 32'(capturing), 1);
    foreach (words[k]) strobeWord(words[k]);
    waitDone();
    check("R5 done", 32'(done), 1);
    check("R5 capturing low", 32'(capturing), 0);
    check("R5 count", 32'(samplesTaken), 5);
    check("R10 peak", 32'(peakOverlap), 3);
    foreach (words[k]) begin
      readWord(k, v);
      check("R3 readback", v, words[k]);
    end
    longestOf(0, v); check("R7 bit0", v, 3);
    longestOf(1, v); check("R7 bit1", v, 3);
    longestOf(2, v); check("R7 bit2", v, 2);
    longestOf(3, v); check("R7 bit3", v, 0);
    strobeWord(32'hAAAA_0000); // R11: after end
    check("R11 post-done count", 32'(samplesTaken), 5);
    readWord(5, v);
    check("R11 post-done buffer", v, 0);
    check("R5 done held", 32'(done), 1);
  endtask

  task automatic testOpenRun();
    logic [31:0] v;
    startRun(3);
    repeat (3) strobeWord(32'hF000_0000);
    waitDone();
    longestOf(31, v); check("R8 open run closed", v, 3);
    check("R10 peak four", 32'(peakOverlap), 4);
  endtask

  task automatic testSaturate();
    logic [31:0] v;
    startRun(20);
    for (int k = 0; k < 20; k++) strobeWord(32'h1 | (32'(k) << 8));
    waitDone();
    check("R4 count past depth", 32'(samplesTaken), 20);
    longestOf(0, v); check("R9 saturated run", v, 15);
    readWord(0, v); check("R4 first entry kept", v, 32'h1);
    readWord(15, v); check("R4 last entry", v, 32'h0F01);
    check("R10 peak varied", 32'(peakOverlap), 5);
  endtask

  task automatic testClear();
    logic [31:0] v;
    startRun(2);
    check("R2 count cleared", 32'(samplesTaken), 0);
    check("R2 peak cleared", 32'(peakOverlap), 0);
    longestOf(0, v); check("R2 run cleared", v, 0);
    readWord(0, v); check("R2 buffer cleared", v, 0);
    strobeWord(32'hFFFF_FFFF);
    strobeWord(32'h0);
    waitDone();
    check("R10 all bits", 32'(peakOverlap), 32);
    longestOf(17, v); check("R7 single-sample run", v, 1);
  endtask

  task automatic testStop();
    logic [31:0] v;
    startRun(10);
    repeat (3) strobeWord(32'h2);
    @(negedge clk); stopCapture = 1'b1;
    @(negedge clk); stopCapture = 1'b0;
    @(negedge clk);
    check("R6 done on stop", 32'(done), 1);
    check("R6 count", 32'(samplesTaken), 3);
    longestOf(1, v); check("R6 run to stop", v, 3);
  endtask

  task automatic testZero();
    startRun(0);
    @(negedge clk);
    check("R12 done", 32'(done), 1);
    check("R12 count", 32'(samplesTaken), 0);
    check("R12 peak", 32'(peakOverlap), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testOpenRun();
    testSaturate();
    testClear();
    testStop();
    testZero();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule